// File: doc/BRIEF.md
# Serial-bus configuration slave for a clock-output bank

This block is a write-only slave on a two-wire serial bus. It accepts one fixed ten-byte block write and uses three of those bytes to set a bank of 8-bit configuration registers, for example the enable bits of a group of clock outputs. The bus clock and the open-drain data line enter through synchronisers clocked by a faster system clock. All bus decoding (start, stop, bit shifting, acknowledge) runs in that system clock domain.

A frame is ten bytes. The first is the address byte. It is followed by two header bytes whose values are never examined, and then seven payload bytes. Only the first three payload bytes reach a register. The slave acknowledges a byte by pulling the data line low, and it does so only when the address byte matched. Incoming payload bytes land in shadow registers. The visible outputs take the shadow contents all at once on a stop condition, which keeps a cut-short write from leaving a half-updated bank.

The controller is one state machine with these states:
- `ST_IDLE`: bus free.
- `ST_SHIFT`: collecting eight bits.
- `ST_ACK_LOW`: acknowledge slot, clock still low.
- `ST_ACK_HIGH`: acknowledge slot, clock high.
- `ST_IGNORE`: wait for the next start.

These are its transitions:
- A start moves any state to `ST_SHIFT`.
- A stop moves any state to `ST_IDLE`.
- `ST_SHIFT` moves to `ST_ACK_LOW` on the clock fall after the eighth bit.
- `ST_ACK_LOW` moves to `ST_ACK_HIGH` on the clock rise.
- `ST_ACK_HIGH` moves on the clock fall. It goes to `ST_SHIFT` for the next byte, or to `ST_IGNORE` once ten bytes are counted or the address missed.

Top module: `clkcfg_smb_slave`

## Requirements
- R1: Reset sets `cfg_o` to all ones (24'hFFFFFF) and releases `dat_pull_o`. Both bus inputs are taken as idle-high, so releasing reset with both lines high produces no bus event.
- R2: The slave acknowledges the first byte after a start only if it equals 8'hD2 (7-bit address 7'h69, write bit 0). After any other value the slave acknowledges no byte and changes no register until the next start.
- R3: Bits are taken most-significant first on each rising bus-clock edge. The acknowledge is a low on the data line for the whole ninth clock pulse, and the line is released after that pulse ends.
- R4: Frame bytes 1 and 2 (zero-based) are received and acknowledged when addressed, but their values have no effect. In particular, byte 2 does not change the ten-byte frame length.
- R5: Frame bytes 3, 4 and 5 are payload 0, 1 and 2. They load `cfg_o[7:0]`, `cfg_o[15:8]` and `cfg_o[23:16]` respectively.
- R6: Frame bytes 6 to 9 are acknowledged when addressed but change no register.
- R7: `cfg_o` changes only on a stop condition, and only when the address matched and at least six frame bytes have arrived. All three registers then change together. A stop after fewer bytes, or a repeated start, leaves `cfg_o` unchanged.
- R8: Bytes after the tenth are not acknowledged and are ignored until the next start.
- R9: A start or stop at any point resets the byte counter and clears the address-match flag. A repeated start therefore begins a fresh, fully valid frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, faster than the bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_clk_i | input | 1 | Serial bus clock, idle high |
| bus_dat_i | input | 1 | Serial bus data line as seen on the wire, idle high |
| dat_pull_o | output | 1 | When high, the data line is pulled low (acknowledge) |
| cfg_o | output | 24 | Committed configuration registers, payload 0 in bits 7:0 |

## Verification
Two functions can meet in a single system cycle. A stop condition commits the shadow registers, and in that same cycle it clears the address-match flag and the byte counter on which the commit decision depends. The bench provokes this with stops placed right after the sixth byte, after the tenth, after an eleventh, and after shorter frames. It judges the result by whether `cfg_o` afterwards holds the payload bytes of the frame that was just sent or keeps its previous value. Repeated starts that abort a matched frame are mixed in, to show that a start clears the flag without committing.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_ACK_LOW,
        ST_ACK_HIGH,
        ST_IGNORE
    } smb_state_e;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_lane
        logic [STAGES-1:0] chain_q;
        // lines are idle-high, so the chain resets to ones
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q <= '1;
            else         chain_q <= {chain_q[STAGES-2:0], d_i[g]};
        end
        assign q_o[g] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/smb_cond_detect.sv
module smb_cond_detect (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic scl_q, sda_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    assign scl_rise_o = scl_i & ~scl_q;
    assign scl_fall_o = ~scl_i & scl_q;
    // data edges while the clock stays high
    assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
    assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/smb_cfg_bank.sv
module smb_cfg_bank #(
    parameter int NUM_REGS = 3,
    parameter int REG_W    = 8,
    parameter int IDX_W    = 2
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      wr_en_i,
    input  logic [IDX_W-1:0]          wr_idx_i,
    input  logic [REG_W-1:0]          wr_data_i,
    input  logic                      commit_i,
    output logic [NUM_REGS*REG_W-1:0] cfg_o
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [REG_W-1:0] shadow_q, live_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                shadow_q <= '1;
                live_q   <= '1;
            end else begin
                if (wr_en_i && wr_idx_i == IDX_W'(g)) shadow_q <= wr_data_i;
                if (commit_i)                         live_q   <= shadow_q;
            end
        end
        assign cfg_o[g*REG_W +: REG_W] = live_q;
    end
endmodule

// File: rtl/clkcfg_smb_slave.sv
module clkcfg_smb_slave
    import smb_cfg_pkg::*;
#(
    parameter int         NUM_REGS    = 3,
    parameter int         TOTAL_BYTES = 10,
    parameter int         HDR_BYTES   = 3,
    parameter logic [7:0] DEV_ADDR    = 8'hD2,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    bus_clk_i,
    input  logic                    bus_dat_i,
    output logic                    dat_pull_o,
    output logic [NUM_REGS*8-1:0]   cfg_o
);
    localparam int CFG_W = NUM_REGS * 8;
    localparam int CNT_W = $clog2(TOTAL_BYTES + 1);
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam logic [CNT_W-1:0] TOTAL_C = CNT_W'(TOTAL_BYTES);
    localparam logic [CNT_W-1:0] HDR_C   = CNT_W'(HDR_BYTES);
    localparam logic [CNT_W-1:0] LAST_C  = CNT_W'(HDR_BYTES + NUM_REGS);

    logic [1:0] sync_q;
    logic       scl_s, sda_s;
    logic       scl_rise, scl_fall, start_det, stop_det;

    smb_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   ({bus_clk_i, bus_dat_i}),
        .q_o   (sync_q)
    );
    assign scl_s = sync_q[1];
    assign sda_s = sync_q[0];

    smb_cond_detect u_det (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .scl_i     (scl_s),
        .sda_i     (sda_s),
        .scl_rise_o(scl_rise),
        .scl_fall_o(scl_fall),
        .start_o   (start_det),
        .stop_o    (stop_det)
    );

    smb_state_e       state_q, state_d;
    logic [3:0]       bit_cnt_q;
    logic [7:0]       shift_q;
    logic [CNT_W-1:0] byte_cnt_q;
    logic             addr_ok_q, ack_en_q;
    logic             byte_done, addr_hit, commit, wr_en;
    logic [IDX_W-1:0] wr_idx;

    assign byte_done = (state_q == ST_SHIFT) && scl_fall && (bit_cnt_q == 4'd8);
    assign addr_hit  = (byte_cnt_q == '0) && (shift_q == DEV_ADDR);
    assign wr_idx    = IDX_W'(byte_cnt_q - HDR_C);

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (start_det) begin
            state_d = ST_SHIFT;
        end else if (stop_det) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_SHIFT:    if (byte_done) state_d = ST_ACK_LOW;
                ST_ACK_LOW:  if (scl_rise)  state_d = ST_ACK_HIGH;
                ST_ACK_HIGH: if (scl_fall)
                                 state_d = (byte_cnt_q == TOTAL_C || !addr_ok_q)
                                           ? ST_IGNORE : ST_SHIFT;
                ST_IGNORE:   state_d = ST_IGNORE;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // datapath registers: shifter, counters, match flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            bit_cnt_q  <= '0;
            shift_q    <= '0;
            byte_cnt_q <= '0;
            addr_ok_q  <= 1'b0;
            ack_en_q   <= 1'b0;
        end else if (start_det || stop_det) begin
            bit_cnt_q  <= '0;
            byte_cnt_q <= '0;
            addr_ok_q  <= 1'b0;
            ack_en_q   <= 1'b0;
        end else begin
            if (state_q == ST_SHIFT && scl_rise) begin
                shift_q   <= {shift_q[6:0], sda_s};
                bit_cnt_q <= bit_cnt_q + 4'd1;
            end
            if (byte_done) begin
                bit_cnt_q  <= '0;
                byte_cnt_q <= byte_cnt_q + 1'b1;
                if (byte_cnt_q == '0) begin
                    addr_ok_q <= addr_hit;
                    ack_en_q  <= addr_hit;
                end else begin
                    ack_en_q  <= addr_ok_q;
                end
            end
        end
    end

    // outputs of the state machine
    always_comb begin
        dat_pull_o = 1'b0;
        wr_en      = 1'b0;
        commit     = stop_det && addr_ok_q && (byte_cnt_q >= LAST_C);
        unique case (state_q)
            ST_SHIFT:    wr_en = byte_done && addr_ok_q &&
                                 (byte_cnt_q >= HDR_C) && (byte_cnt_q < LAST_C);
            ST_ACK_LOW,
            ST_ACK_HIGH: dat_pull_o = ack_en_q;
            ST_IDLE,
            ST_IGNORE:   dat_pull_o = 1'b0;
            default:     dat_pull_o = 1'b0;
        endcase
    end

    smb_cfg_bank #(.NUM_REGS(NUM_REGS), .REG_W(8), .IDX_W(IDX_W)) u_bank (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_en_i  (wr_en),
        .wr_idx_i (wr_idx),
        .wr_data_i(shift_q),
        .commit_i (commit),
        .cfg_o    (cfg_o)
    );
endmodule

// File: rtl/smb_cfg_chk.sv
module smb_cfg_chk
    import smb_cfg_pkg::*;
#(
    parameter int CNT_W       = 4,
    parameter int TOTAL_BYTES = 10,
    parameter int CFG_W       = 24
) (
    input logic             clk_i,
    input logic             rst_ni,
    input smb_state_e       state,
    input logic             dat_pull_o,
    input logic [CFG_W-1:0] cfg_o,
    input logic             commit,
    input logic             addr_ok,
    input logic [CNT_W-1:0] byte_cnt,
    input logic             start_det,
    input logic             stop_det
);
    assert_pull_in_slot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dat_pull_o |-> (state == ST_ACK_LOW || state == ST_ACK_HIGH));

    assert_pull_needs_match_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dat_pull_o |-> addr_ok);

    assert_ignore_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state == ST_IGNORE) |-> !dat_pull_o);

    assert_cnt_cap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        byte_cnt <= CNT_W'(TOTAL_BYTES));

    assert_start_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_det |=> (byte_cnt == '0 && !addr_ok && state == ST_SHIFT));

    assert_stop_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_det |=> (byte_cnt == '0 && !addr_ok && state == ST_IDLE));

    assert_cfg_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !commit |=> $stable(cfg_o));
endmodule

bind clkcfg_smb_slave smb_cfg_chk #(
    .CNT_W(CNT_W), .TOTAL_BYTES(TOTAL_BYTES), .CFG_W(CFG_W)
) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .state     (state_q),
    .dat_pull_o(dat_pull_o),
    .cfg_o     (cfg_o),
    .commit    (commit),
    .addr_ok   (addr_ok_q),
    .byte_cnt  (byte_cnt_q),
    .start_det (start_det),
    .stop_det  (stop_det)
);

// File: tb/clkcfg_smb_slave_bench.sv
module clkcfg_smb_slave_bench;
    localparam int H = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        pull;
    logic [23:0] cfg;
    logic        line;
    logic [7:0]  frame_q [12];
    logic [23:0] exp_cfg = 24'hFFFFFF;
    int          checks = 0;
    int          fails  = 0;
    bit          done   = 1'b0;

    always #4 clk = ~clk;
    assign line = m_sda & ~pull;

    clkcfg_smb_slave u_clkcfg_smb_slave (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .bus_clk_i (m_scl),
        .bus_dat_i (line),
        .dat_pull_o(pull),
        .cfg_o     (cfg)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic hw(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; hw(H);
        m_scl = 1'b1; hw(H);
        m_sda = 1'b0; hw(H);
        m_scl = 1'b0; hw(H);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; hw(H);
        m_scl = 1'b1; hw(H);
        m_sda = 1'b1; hw(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; hw(H);
            m_scl = 1'b1; hw(H);
            m_scl = 1'b0;
        end
        m_sda = 1'b1; hw(H);
        m_scl = 1'b1; hw(H / 2);
        acked = (line == 1'b0);
        hw(H - H / 2);
        m_scl = 1'b0;
    endtask

    function automatic string tag_of(input int k);
        if (k == 0)       return "R2 address ack";
        else if (k < 3)   return "R4 header ack";
        else if (k < 6)   return "R5 payload ack";
        else if (k < 10)  return "R6 tail ack";
        else              return "R8 extra byte no ack";
    endfunction

    function automatic bit exp_ack(input logic [7:0] a, input int k);
        return (a == 8'hD2) && (k < 10);
    endfunction

    // sends frame_q[0..n-1]; ends with stop if do_stop
    task automatic run_frame(input int n, input bit do_stop);
        bit a;
        bit hit;
        hit = (frame_q[0] == 8'hD2);
        bus_start();
        for (int k = 0; k < n; k++) begin
            send_byte(frame_q[k], a);
            chk(a == exp_ack(frame_q[0], k), tag_of(k), 32'(a),
                32'(exp_ack(frame_q[0], k)));
        end
        hw(3);
        chk(pull == 1'b0, "R3 release after ack", 32'(pull), 32'd0);
        if (do_stop) begin
            bus_stop();
            if (hit && n >= 6) exp_cfg = {frame_q[5], frame_q[4], frame_q[3]};
            chk(cfg == exp_cfg, "R7 outputs after stop", 32'(cfg), 32'(exp_cfg));
        end else begin
            chk(cfg == exp_cfg, "R7 no commit without stop", 32'(cfg), 32'(exp_cfg));
        end
    endtask

    task automatic fill(input logic [7:0] a, input logic [7:0] c, input logic [7:0] n,
                        input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2);
        frame_q[0] = a; frame_q[1] = c; frame_q[2] = n;
        frame_q[3] = d0; frame_q[4] = d1; frame_q[5] = d2;
        for (int i = 6; i < 12; i++) frame_q[i] = 8'($urandom);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        hw(5);
        rst_n = 1'b1;
        hw(6);
        // R1: reset value, no pull, no event from idle-high lines
        chk(cfg == 24'hFFFFFF, "R1 reset cfg", 32'(cfg), 32'hFFFFFF);
        chk(pull == 1'b0, "R1 reset pull", 32'(pull), 32'd0);

        // R3/R5: MSB-first payload with asymmetric bit patterns
        fill(8'hD2, 8'h00, 8'h07, 8'h80, 8'h01, 8'h3C);
        run_frame(10, 1'b1);
        chk(cfg == 24'h3C0180, "R3 bit order", 32'(cfg), 32'h3C0180);

        // R4: header values and a byte count of 1 do not shorten the frame
        fill(8'hD2, 8'hFF, 8'h01, 8'h11, 8'h22, 8'h33);
        run_frame(10, 1'b1);

        // R2: read-bit address is rejected, nothing changes
        fill(8'hD3, 8'h00, 8'h07, 8'hAA, 8'hBB, 8'hCC);
        run_frame(10, 1'b1);

        // R7: stop after five bytes (truncated) keeps old values
        fill(8'hD2, 8'h00, 8'h07, 8'h5A, 8'h5B, 8'h5C);
        run_frame(5, 1'b1);
        // R7: stop right after sixth byte commits
        run_frame(6, 1'b1);

        // R8: eleventh and twelfth bytes not acknowledged
        fill(8'hD2, 8'h00, 8'h07, 8'h01, 8'h02, 8'h03);
        run_frame(12, 1'b1);

        // R9: matched frame aborted by repeated start, then mismatched frame + stop
        fill(8'hD2, 8'h00, 8'h07, 8'h66, 8'h77, 8'h88);
        run_frame(8, 1'b0);
        fill(8'h12, 8'h00, 8'h07, 8'h99, 8'h99, 8'h99);
        run_frame(10, 1'b1);
        chk(cfg == 24'h030201, "R9 flag cleared by start", 32'(cfg), 32'h030201);
        // R9: repeated start then a full valid frame
        fill(8'hD2, 8'h00, 8'h07, 8'h44, 8'h45, 8'h46);
        run_frame(4, 1'b0);
        fill(8'hD2, 8'h00, 8'h07, 8'hE1, 8'hE2, 8'hE3);
        run_frame(10, 1'b1);

        // random frames
        for (int t = 0; t < 40; t++) begin
            logic [7:0] a;
            int n;
            bit st;
            a  = (($urandom % 3) == 0) ? 8'($urandom) : 8'hD2;
            n  = 1 + int'($urandom % 12);
            st = (($urandom % 4) != 0) || (t == 39);
            fill(a, 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
                 8'($urandom));
            run_frame(n, st);
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule